// File: doc/BRIEF.md
# Synthesizer Register Load Sequencer

This block programs an external frequency synthesizer through a three-wire serial link: a serial clock, a data line and a latch strobe. A configuration command sends six 32-bit register words, starting at register 5 and ending at register 0. The latch strobe pulses after each word. The register-0 write starts the tuning, so the block always sends it last. It also holds that write back until a programmable settling interval has passed since the latch edge of the word before it. A power-down command rewrites only register 2 with its power-down bit set. A wake command rewrites register 2 with that bit cleared, waits out the settling interval, and then writes register 0. As a recovery aid, the block can send register 0 a second time after a separate programmable delay.

The register contents come from an input port. The block places each register's index in the low three bits of its word. The serial clock is divided down from the system clock: each half-period lasts `HALF_DIV` system cycles, so `HALF_DIV` is set to the system frequency divided by twice the wanted serial rate. The settling and retry delays are given in system cycles.

The controller is a five-state machine:
- `S_IDLE` waits for a command. An accepted command moves it to `S_SHIFT`.
- `S_SHIFT` sends 32 bits. After the last bit it moves to `S_LATCH`.
- `S_LATCH` holds the strobe high for one bit period. After the final word it returns to `S_IDLE`. Otherwise it moves to `S_GAP`.
- `S_GAP` idles for `GAP_BITS` bit periods. If the next word is register 0 it moves to `S_WAIT`. Otherwise it moves back to `S_SHIFT`.
- `S_WAIT` holds until the delay counter has expired, then moves to `S_SHIFT`.

Top module: `synth_load_seq`

## Requirements
- R1: A configuration command sends six words, for registers 5, 4, 3, 2, 1 and 0 in that order. Each word is 32 bits, most significant bit first. The data line changes only while the serial clock is low and holds steady while it is high.
- R2: Bits [2:0] of every word sent equal the register index. All other bits come from `cfg_words[index]`, with the power-down bit (bit `PD_BIT`, default 5, of register 2) overridden only by power-down and wake commands.
- R3: Each serial-clock half-period lasts `HALF_DIV` system cycles. The latch strobe rises when the serial clock falls after the 32nd bit, stays high for exactly `2*HALF_DIV` cycles, and the serial clock stays low while the strobe is high.
- R4: When no wait applies, consecutive latch rising edges are exactly `2*HALF_DIV*(33+GAP_BITS)` system cycles apart.
- R5: The latch rising edge of register 0 comes L to L+2*HALF_DIV cycles after the previous word's latch rising edge, where L = max(`settle_cycles`, 2*HALF_DIV*(1+GAP_BITS)) + 64*HALF_DIV.
- R6: A power-down command sends exactly one word: register 2 with the power-down bit set.
- R7: A wake command sends register 2 with the power-down bit cleared, then register 0, with the timing of R5.
- R8: If `retry_en` is high when a command ending in register 0 is accepted, register 0 is sent once more. Its latch rising edge follows the first one by the interval of R5, with `retry_cycles` in place of `settle_cycles`. A power-down command is never repeated.
- R9: `busy_o` rises in the cycle after a command is accepted and falls in the cycle the last strobe pulse ends. `done_o` is high for exactly that one cycle.
- R10: Commands that arrive while busy are ignored. When several commands arrive at once, configuration wins over wake, and wake wins over power-down.
- R11: Reset drives the serial clock, data, strobe, `busy_o` and `done_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_cfg | input | 1 | Full configuration command |
| start_pdown | input | 1 | Power-down command |
| start_wake | input | 1 | Wake command |
| retry_en | input | 1 | Repeat the final register-0 write |
| settle_cycles | input | CNT_W | Minimum cycles from the preceding latch edge to the register-0 latch edge |
| retry_cycles | input | CNT_W | Delay between the two register-0 latch edges |
| cfg_words | input | NUM_REGS x WORD_W | Register contents, indexed by register number |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data |
| le_o | output | 1 | Latch strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Full configurations are run with four register patterns: all ones, all zeros, a mixed pattern and a walking one. Together these expose a wrong bit order, stuck data, a missing address overwrite or a wrong word order. The settling sweep covers values below, near and well above the natural word spacing, so it separates a missing wait, a wait started from the wrong edge, and a wait that ignores its input. Power-down, wake and retry runs, with and without `retry_en`, check which words each command sends and their counts. Commands injected mid-sequence and commands asserted together test rejection while busy and the priority order.

// File: rtl/sseq_pkg.sv
package sseq_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_SHIFT,
        S_LATCH,
        S_GAP,
        S_WAIT
    } seq_state_t;

    typedef enum logic [1:0] {
        M_FULL,
        M_PDOWN,
        M_WAKE
    } seq_mode_t;
endpackage

// File: rtl/sseq_tick.sv
module sseq_tick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick_o = en && (cnt == LAST);
endmodule

// File: rtl/sseq_wait.sv
module sseq_wait #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load_i) begin
            cnt <= val_i;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done_o = (cnt == '0);

    // R5
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !load_i) |=> done_o);
endmodule

// File: rtl/synth_load_seq.sv
module synth_load_seq
    import sseq_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int GAP_BITS = 2,
    parameter int WORD_W   = 32,
    parameter int NUM_REGS = 6,
    parameter int ADDR_W   = 3,
    parameter int PD_REG   = 2,
    parameter int PD_BIT   = 5,
    parameter int CNT_W    = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start_cfg,
    input  logic                             start_pdown,
    input  logic                             start_wake,
    input  logic                             retry_en,
    input  logic [CNT_W-1:0]                 settle_cycles,
    input  logic [CNT_W-1:0]                 retry_cycles,
    input  logic [NUM_REGS-1:0][WORD_W-1:0]  cfg_words,
    output logic                             sclk_o,
    output logic                             sdata_o,
    output logic                             le_o,
    output logic                             busy_o,
    output logic                             done_o
);
    localparam int IDX_W = $clog2(NUM_REGS);
    localparam int BIT_W = $clog2(WORD_W);
    localparam int GAP_T = 2 * GAP_BITS;
    localparam int TC_W  = $clog2(GAP_T + 2);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_REGS - 1);
    localparam logic [IDX_W-1:0] PD_IDX  = IDX_W'(PD_REG);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    seq_state_t       state, nxt;
    seq_mode_t        mode, start_mode;
    logic [IDX_W-1:0] idx, first_idx, next_idx;
    logic [WORD_W-1:0] sreg;
    logic [BIT_W-1:0] bitcnt;
    logic             phase;
    logic [TC_W-1:0]  tcnt;
    logic             retry_pend;
    logic             sclk_q, sdata_q, le_q, done_q;
    logic             tick, wdone, wload;
    logic [CNT_W-1:0] wval;
    logic             start_any, is_last, redo;
    logic             frame_end, latch_end, gap_end;

    function automatic logic [WORD_W-1:0] word_for(input logic [IDX_W-1:0] i,
                                                   input seq_mode_t m);
        logic [WORD_W-1:0] w;
        w = cfg_words[i];
        if (i == PD_IDX) begin
            if (m == M_PDOWN)     w[PD_BIT] = 1'b1;
            else if (m == M_WAKE) w[PD_BIT] = 1'b0;
        end
        w[ADDR_W-1:0] = ADDR_W'(i);
        return w;
    endfunction

    sseq_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (state != S_IDLE),
        .tick_o (tick)
    );

    sseq_wait #(.CNT_W(CNT_W)) u_wait (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (wload),
        .val_i  (wval),
        .done_o (wdone)
    );

    assign start_any  = start_cfg | start_pdown | start_wake;
    assign start_mode = start_cfg ? M_FULL : (start_wake ? M_WAKE : M_PDOWN);
    assign first_idx  = (start_mode == M_FULL) ? TOP_IDX : PD_IDX;
    assign is_last    = (idx == '0) || (mode == M_PDOWN);
    assign next_idx   = (mode == M_FULL) ? idx - 1'b1 : '0;
    assign redo       = (idx == '0) && retry_pend;

    assign frame_end = (state == S_SHIFT) && tick && phase && (bitcnt == LAST_BIT);
    assign latch_end = (state == S_LATCH) && tick && (tcnt == TC_W'(1));
    assign gap_end   = (state == S_GAP) && tick && (tcnt == TC_W'(GAP_T - 1));

    assign wload = frame_end && ((!is_last && next_idx == '0) || redo);
    assign wval  = redo ? retry_cycles : settle_cycles;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start_any) nxt = S_SHIFT;
            S_SHIFT: if (frame_end) nxt = S_LATCH;
            S_LATCH: if (latch_end) nxt = (is_last && !redo) ? S_IDLE : S_GAP;
            S_GAP:   if (gap_end)   nxt = (idx == '0) ? S_WAIT : S_SHIFT;
            S_WAIT:  if (tick && wdone) nxt = S_SHIFT;
            default: nxt = S_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode       <= M_FULL;
            idx        <= '0;
            sreg       <= '0;
            bitcnt     <= '0;
            phase      <= 1'b0;
            tcnt       <= '0;
            retry_pend <= 1'b0;
            sclk_q     <= 1'b0;
            sdata_q    <= 1'b0;
            le_q       <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start_any) begin
                        mode       <= start_mode;
                        idx        <= first_idx;
                        retry_pend <= retry_en && (start_mode != M_PDOWN);
                        sreg       <= word_for(first_idx, start_mode);
                        sdata_q    <= word_for(first_idx, start_mode)[WORD_W-1];
                        bitcnt     <= '0;
                        phase      <= 1'b0;
                    end
                end
                S_SHIFT: begin
                    if (tick) begin
                        if (!phase) begin
                            sclk_q <= 1'b1;
                            phase  <= 1'b1;
                        end else begin
                            sclk_q <= 1'b0;
                            phase  <= 1'b0;
                            if (bitcnt == LAST_BIT) begin
                                le_q    <= 1'b1;
                                sdata_q <= 1'b0;
                                tcnt    <= '0;
                            end else begin
                                bitcnt  <= bitcnt + 1'b1;
                                sreg    <= sreg << 1;
                                sdata_q <= sreg[WORD_W-2];
                            end
                        end
                    end
                end
                S_LATCH: begin
                    if (tick) begin
                        tcnt <= tcnt + 1'b1;
                        if (latch_end) begin
                            le_q <= 1'b0;
                            tcnt <= '0;
                            if (is_last && !redo) begin
                                done_q <= 1'b1;
                            end else if (redo) begin
                                retry_pend <= 1'b0;
                            end else begin
                                idx <= next_idx;
                            end
                        end
                    end
                end
                S_GAP: begin
                    if (tick) begin
                        tcnt <= tcnt + 1'b1;
                        if (gap_end) begin
                            tcnt <= '0;
                            if (idx != '0) begin
                                sreg    <= word_for(idx, mode);
                                sdata_q <= word_for(idx, mode)[WORD_W-1];
                                bitcnt  <= '0;
                            end
                        end
                    end
                end
                S_WAIT: begin
                    if (tick && wdone) begin
                        sreg    <= word_for(idx, mode);
                        sdata_q <= word_for(idx, mode)[WORD_W-1];
                        bitcnt  <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign sclk_o  = sclk_q;
    assign sdata_o = sdata_q;
    assign le_o    = le_q;
    assign busy_o  = (state != S_IDLE);
    assign done_o  = done_q;

    // R3
    le_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        le_o |-> !sclk_o);

    // R1
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> $stable(sdata_o));

    // R9
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R9
    done_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!sclk_o && !le_o));

    // R10
    busy_keep_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_any) |=> $stable(mode));
endmodule

// File: tb/synth_load_seq_bench.sv
module synth_load_seq_bench;
    localparam int H  = 4;
    localparam int G  = 2;
    localparam int CW = 16;
    localparam int PDB = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_cfg = 1'b0, start_pdown = 1'b0, start_wake = 1'b0, retry_en = 1'b0;
    logic [CW-1:0] settle_cycles = '0, retry_cycles = '0;
    logic [5:0][31:0] cfg_words = '0;
    logic sclk_o, sdata_o, le_o, busy_o, done_o;

    int tests = 0;
    int fails = 0;
    longint cyc = 0;

    logic [31:0] acc;
    logic [31:0] got [0:15];
    longint      gt  [0:15];
    int          gbits [0:15];
    int          n = 0, nbits = 0, ndone = 0, lew = 0, sclk_in_le = 0;
    longint      le_rise = 0;
    logic        sclk_p = 1'b0, le_p = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    synth_load_seq #(.HALF_DIV(H), .GAP_BITS(G), .PD_BIT(PDB), .CNT_W(CW)) u_synth_load_seq (
        .clk(clk), .rst_n(rst_n), .start_cfg(start_cfg), .start_pdown(start_pdown),
        .start_wake(start_wake), .retry_en(retry_en), .settle_cycles(settle_cycles),
        .retry_cycles(retry_cycles), .cfg_words(cfg_words), .sclk_o(sclk_o),
        .sdata_o(sdata_o), .le_o(le_o), .busy_o(busy_o), .done_o(done_o)
    );

    always @(negedge clk) begin
        if ((start_cfg | start_pdown | start_wake) && !busy_o) begin
            n = 0; nbits = 0; ndone = 0; sclk_in_le = 0;
        end
        if (sclk_o && !sclk_p) begin
            acc = {acc[30:0], sdata_o};
            nbits = nbits + 1;
        end
        if (le_o && sclk_o) sclk_in_le = sclk_in_le + 1;
        if (le_o && !le_p) begin
            if (n < 16) begin
                got[n] = acc; gt[n] = cyc; gbits[n] = nbits;
            end
            n = n + 1; nbits = 0; le_rise = cyc;
        end
        if (!le_o && le_p) lew = int'(cyc - le_rise);
        if (done_o) ndone = ndone + 1;
        sclk_p = sclk_o;
        le_p = le_o;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int p, input int i);
        case (p)
            0: return 32'hFFFF_FFFF;
            1: return 32'h0;
            2: return 32'hA5C3_5A3C ^ (32'(i) * 32'h1111_1117);
            default: return 32'h1 << (i * 5 + 3);
        endcase
    endfunction

    // mode 0 config, 1 power-down, 2 wake
    function automatic logic [31:0] exp_word(input int i, input int m);
        logic [31:0] w;
        w = cfg_words[i];
        if (i == 2 && m == 1) w[PDB] = 1'b1;
        if (i == 2 && m == 2) w[PDB] = 1'b0;
        w[2:0] = 3'(i);
        return w;
    endfunction

    function automatic longint lo_bound(input longint d);
        longint base;
        base = 2 * H * (1 + G);
        return ((d > base) ? d : base) + 64 * H;
    endfunction

    task automatic launch(input bit c, input bit p, input bit w);
        @(negedge clk);
        start_cfg = c; start_pdown = p; start_wake = w;
        @(negedge clk);
        start_cfg = 0; start_pdown = 0; start_wake = 0;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 30000 && ndone == 0; k++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        for (int k = 0; k < 200000; k++) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!sclk_o && !sdata_o && !le_o && !busy_o && !done_o, "R11 reset outputs",
            {sclk_o, sdata_o, le_o, busy_o, done_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2 R3 R4 R9: pattern sweep over full configuration
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < 6; i++) cfg_words[i] = pat(p, i);
            settle_cycles = 0;
            launch(1, 0, 0);
            chk(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
            wait_done();
            chk(n == 6, "R1 word count", n, 6);
            for (int k = 0; k < 6; k++) begin
                chk(got[k] == exp_word(5 - k, 0), "R1 R2 word value", got[k], exp_word(5 - k, 0));
                chk(gbits[k] == 32, "R1 bits per word", gbits[k], 32);
            end
            for (int k = 0; k < 4; k++)
                chk(gt[k+1] - gt[k] == 2 * H * (33 + G), "R4 word spacing",
                    gt[k+1] - gt[k], 2 * H * (33 + G));
            chk(lew == 2 * H, "R3 latch width", lew, 2 * H);
            chk(sclk_in_le == 0, "R3 sclk low in latch", sclk_in_le, 0);
            chk(ndone == 1 && !busy_o, "R9 done once busy low", ndone, 1);
        end

        // R5 settle sweep
        for (int s = 0; s < 5; s++) begin
            longint d, lo;
            case (s)
                0: settle_cycles = 0;
                1: settle_cycles = 20;
                2: settle_cycles = 150;
                3: settle_cycles = 400;
                default: settle_cycles = 900;
            endcase
            launch(1, 0, 0);
            wait_done();
            d  = gt[5] - gt[4];
            lo = lo_bound(longint'(settle_cycles));
            chk(n == 6 && d >= lo && d <= lo + 2 * H, "R5 settle interval", d, lo);
        end

        // R6 power-down, never retried (R8)
        retry_en = 1'b1; retry_cycles = 300;
        launch(0, 1, 0);
        wait_done();
        chk(n == 1, "R6 R8 power-down count", n, 1);
        chk(got[0] == exp_word(2, 1), "R6 power-down word", got[0], exp_word(2, 1));
        retry_en = 1'b0;

        // R7 wake
        settle_cycles = 500;
        launch(0, 0, 1);
        wait_done();
        chk(n == 2, "R7 wake count", n, 2);
        chk(got[0] == exp_word(2, 2), "R7 wake reg2", got[0], exp_word(2, 2));
        chk(got[1] == exp_word(0, 2), "R7 wake reg0", got[1], exp_word(0, 2));
        chk(gt[1] - gt[0] >= lo_bound(500) && gt[1] - gt[0] <= lo_bound(500) + 2 * H,
            "R7 wake interval", gt[1] - gt[0], lo_bound(500));

        // R8 retry on full configuration and wake
        retry_en = 1'b1; retry_cycles = 700; settle_cycles = 40;
        launch(1, 0, 0);
        wait_done();
        chk(n == 7, "R8 retry count", n, 7);
        chk(got[6] == exp_word(0, 0), "R8 retry word", got[6], exp_word(0, 0));
        chk(gt[6] - gt[5] >= lo_bound(700) && gt[6] - gt[5] <= lo_bound(700) + 2 * H,
            "R8 retry interval", gt[6] - gt[5], lo_bound(700));
        launch(0, 0, 1);
        wait_done();
        chk(n == 3, "R8 wake retry count", n, 3);
        retry_en = 1'b0;

        // R10 start while busy ignored
        launch(1, 0, 0);
        repeat (300) @(negedge clk);
        start_pdown = 1'b1; start_wake = 1'b1;
        @(negedge clk);
        start_pdown = 1'b0; start_wake = 1'b0;
        wait_done();
        chk(n == 6, "R10 busy start ignored", n, 6);

        // R10 priority
        launch(1, 1, 1);
        wait_done();
        chk(n == 6, "R10 config over others", n, 6);
        launch(0, 1, 1);
        wait_done();
        chk(n == 2 && got[0] == exp_word(2, 2), "R10 wake over power-down", n, 2);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule